// File: doc/BRIEF.md
# OSD Character Raster Position Generator

This block places an on-screen-display text grid inside a video frame. It counts horizontal-sync strobes after each vertical-sync strobe, and dot-clock enables after each horizontal-sync strobe. From those counts it reports which text row and column the raster is in, which dot row and dot column of the glyph cell is being drawn, and a flag that is high only inside the character area. Downstream pixel logic uses these coordinates to address a font and a character store. That logic is outside this block.

The grid is 24 columns by 12 rows of 12x18-dot cells. A select input can shorten it to 10 rows. The top edge is a fixed line-standard origin plus twice a 6-bit vertical position. The left edge is twice a 6-bit horizontal position, counted in dot periods. Each font dot can be stretched over 1, 2 or 3 lines and over 1, 2 or 3 dot periods. The first text row has its own size codes. All other rows share a second pair. Settings are captured into registers on a load strobe.

Top module: `osd_raster_pos`

## Requirements
- R1: While `char_active` is high, `txt_col` is below 24, `dot_col` is below 12 and `dot_row` is below 18. Each cell is 12 dots wide and 18 glyph lines tall.
- R2: Let L be the number of `hsync_stb` pulses since the last `vsync_stb`. The first active line is L = 20 + 2·VP when `cfg_line625` is 0, and L = 25 + 2·VP when it is 1.
- R3: Let P be the number of `dot_en` cycles since the last `hsync_stb`. The first active dot of a line is P = 2·HP. When HP is 0, the dot is active in the cycle after the strobe.
- R4: A 2-bit size code maps 00 to a factor of 1, 01 to 2, 10 to 3 and 11 to 1. The factor is the number of lines (vertically) or dot periods (horizontally) per font dot.
- R5: Text row 0 uses `cfg_vsize_first` and `cfg_hsize_first`. Text rows 1 and above use `cfg_vsize_rest` and `cfg_hsize_rest`.
- R6: With `cfg_rows10` at 0 the grid has 12 text rows. With it at 1 the grid has 10 rows, and the line after row 9 ends is inactive.
- R7: Dots after column 23 of a line stay inactive up to the next `hsync_stb`, and the column count does not wrap. Lines after the last row stay inactive up to the next `vsync_stb`.
- R8: `vsync_stb` restarts the line count and clears `char_active` in the next cycle. `hsync_stb` restarts the dot count, and it takes priority over a `dot_en` in the same cycle.
- R9: Reset clears all settings and outputs to 0. Setting inputs have no effect until `cfg_load` is pulsed.
- R10: In a cycle with neither `dot_en` nor `hsync_stb`, the dot position and all outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_load | input | 1 | Capture all cfg_* inputs |
| cfg_line625 | input | 1 | 0: 525-line origin, 1: 625-line origin |
| cfg_vpos | input | 6 | Vertical position VP (units of 2 lines) |
| cfg_hpos | input | 6 | Horizontal position HP (units of 2 dots) |
| cfg_vsize_first | input | 2 | Vertical size code, text row 0 |
| cfg_vsize_rest | input | 2 | Vertical size code, rows 1 and above |
| cfg_hsize_first | input | 2 | Horizontal size code, text row 0 |
| cfg_hsize_rest | input | 2 | Horizontal size code, rows 1 and above |
| cfg_rows10 | input | 1 | 1 limits the grid to 10 rows |
| hsync_stb | input | 1 | One-cycle horizontal sync strobe |
| vsync_stb | input | 1 | One-cycle vertical sync strobe |
| dot_en | input | 1 | Dot-clock enable |
| txt_row | output | 4 | Text row |
| txt_col | output | 5 | Text column |
| dot_row | output | 5 | Glyph line within the cell |
| dot_col | output | 4 | Glyph dot within the cell |
| char_active | output | 1 | Inside the character grid |

## Verification
The bench builds the block with its default parameters: 6-bit positions, 24x12 cells of 12x18 dots, a 10-row alternative, and origins of 20 and 25 lines. These defaults keep every size-code pairing and both origins within reach. They also reach the extreme positions: a start line of 146 and a start dot of 126. A full frame under triple magnification fits in a few thousand cycles. This lets each vector walk every line of the frame and sweep whole lines across both row-size boundaries and the end of the grid.

// File: rtl/osd_pos_pkg.sv
// Package: shared size-code encoding for the OSD raster position logic.
// Assumes a 2-bit size code per direction.
package osd_pos_pkg;

    typedef enum logic [1:0] {
        SZ_X1  = 2'b00,
        SZ_X2  = 2'b01,
        SZ_X3  = 2'b10,
        SZ_DEF = 2'b11
    } size_code_e;

    // Number of raster units one font dot spans for a size code.
    function automatic logic [1:0] size_mult(input logic [1:0] code);
        case (code)
            SZ_X2:   size_mult = 2'd2;
            SZ_X3:   size_mult = 2'd3;
            default: size_mult = 2'd1;
        endcase
    endfunction

endpackage

// File: rtl/osd_cfg_regs.sv
// Module: holds the OSD placement settings.
// All fields load together on cfg_load and clear on reset.
// Assumes the fields are quasi-static during a frame.
module osd_cfg_regs #(
    parameter int POS_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic             in_line625,
    input  logic [POS_W-1:0] in_vpos,
    input  logic [POS_W-1:0] in_hpos,
    input  logic [1:0]       in_vsz_first,
    input  logic [1:0]       in_vsz_rest,
    input  logic [1:0]       in_hsz_first,
    input  logic [1:0]       in_hsz_rest,
    input  logic             in_rows10,
    output logic             line625,
    output logic [POS_W-1:0] vpos,
    output logic [POS_W-1:0] hpos,
    output logic [1:0]       vsz_first,
    output logic [1:0]       vsz_rest,
    output logic [1:0]       hsz_first,
    output logic [1:0]       hsz_rest,
    output logic             rows10
);

    // Capture the settings on a load strobe; clear them on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line625   <= 1'b0;
            vpos      <= '0;
            hpos      <= '0;
            vsz_first <= '0;
            vsz_rest  <= '0;
            hsz_first <= '0;
            hsz_rest  <= '0;
            rows10    <= 1'b0;
        end else if (cfg_load) begin
            line625   <= in_line625;
            vpos      <= in_vpos;
            hpos      <= in_hpos;
            vsz_first <= in_vsz_first;
            vsz_rest  <= in_vsz_rest;
            hsz_first <= in_hsz_first;
            hsz_rest  <= in_hsz_rest;
            rows10    <= in_rows10;
        end
    end

    // R9: one cycle after reset every setting reads zero
    assert_cfg_cleared_R9: assert property (@(posedge clk)
        !rst_n |=> (!line625 && vpos == '0 && hpos == '0 && vsz_first == '0 &&
                    vsz_rest == '0 && hsz_first == '0 && hsz_rest == '0 && !rows10));

    // R9: settings stay put unless a load strobe arrives
    assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_load |=> ($stable(vpos) && $stable(hpos) && $stable(rows10) && $stable(line625)));

endmodule

// File: rtl/osd_vert_track.sv
// Module: vertical tracker. It counts sync lines after a vertical
// strobe and, from the start line on, steps glyph lines and text rows.
// The row-0 size applies to the first row and the rest size to the others.
// Assumes strobes are one cycle wide and a vertical strobe wins over a
// horizontal one in the same cycle.
module osd_vert_track #(
    parameter int GLYPH_H  = 18,
    parameter int ROWS     = 12,
    parameter int ROWS_ALT = 10,
    parameter int POS_W    = 6,
    parameter int OFS_A    = 20,
    parameter int OFS_B    = 25,
    parameter int ROW_W    = 4,
    parameter int GL_W     = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hsync_stb,
    input  logic             vsync_stb,
    input  logic             line625,
    input  logic [POS_W-1:0] vpos,
    input  logic [1:0]       vsz_first,
    input  logic [1:0]       vsz_rest,
    input  logic             rows10,
    output logic [ROW_W-1:0] row,
    output logic [GL_W-1:0]  gline,
    output logic             v_on
);

    localparam int LINE_MAX = OFS_B + 2 * ((1 << POS_W) - 1) + 1;
    localparam int LINE_W   = $clog2(LINE_MAX + 1);

    logic [LINE_W-1:0] line_cnt;
    logic [LINE_W-1:0] line_nxt;
    logic [LINE_W-1:0] vstart;
    logic [ROW_W-1:0]  row_last;
    logic [1:0]        vrep;
    logic [1:0]        vmag;
    logic              v_done;

    // Start line: the line-standard origin plus twice the position field.
    always_comb begin
        vstart   = (line625 ? LINE_W'(OFS_B) : LINE_W'(OFS_A)) + LINE_W'({vpos, 1'b0});
        line_nxt = (&line_cnt) ? line_cnt : line_cnt + 1'b1;
        row_last = rows10 ? ROW_W'(ROWS_ALT - 1) : ROW_W'(ROWS - 1);
        vmag     = osd_pos_pkg::size_mult((row == '0) ? vsz_first : vsz_rest);
    end

    // Step the line count and the row/glyph-line position on each line strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || vsync_stb) begin
            line_cnt <= '0;
            row      <= '0;
            gline    <= '0;
            vrep     <= '0;
            v_on     <= 1'b0;
            v_done   <= 1'b0;
        end else if (hsync_stb) begin
            line_cnt <= line_nxt;
            if (!v_on && !v_done && line_nxt == vstart) begin
                v_on  <= 1'b1;
                row   <= '0;
                gline <= '0;
                vrep  <= '0;
            end else if (v_on) begin
                if (vrep + 2'd1 < vmag) begin
                    vrep <= vrep + 2'd1;
                end else begin
                    vrep <= '0;
                    if (gline == GL_W'(GLYPH_H - 1)) begin
                        gline <= '0;
                        if (row == row_last) begin
                            v_on   <= 1'b0;
                            v_done <= 1'b1;
                        end else begin
                            row <= row + 1'b1;
                        end
                    end else begin
                        gline <= gline + 1'b1;
                    end
                end
            end
        end
    end

    // R6: the row never passes the selected row count
    assert_row_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        v_on |-> (row <= row_last));

    // R1: glyph line stays inside the cell height
    assert_gline_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        v_on |-> (gline < GL_W'(GLYPH_H)));

    // R8: a vertical strobe ends the character area
    assert_vsync_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        vsync_stb |=> (!v_on && line_cnt == '0));

    // R2: the area opens exactly on the start line
    assert_start_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(v_on) |-> (line_cnt == $past(vstart) && row == '0 && gline == '0));

endmodule

// File: rtl/osd_horz_track.sv
// Module: horizontal tracker. It counts dot enables after a line strobe
// and, from the start dot on, steps glyph dots and text columns.
// It stops after the last column and stays stopped up to the next line
// strobe. Assumes the size code is stable for a whole line.
module osd_horz_track #(
    parameter int GLYPH_W = 12,
    parameter int COLS    = 24,
    parameter int POS_W   = 6,
    parameter int COL_W   = 5,
    parameter int GD_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hsync_stb,
    input  logic             dot_en,
    input  logic [POS_W-1:0] hpos,
    input  logic [1:0]       hsz,
    output logic [COL_W-1:0] col,
    output logic [GD_W-1:0]  gdot,
    output logic             h_on
);

    localparam int DOT_W = $clog2(2 * (1 << POS_W) + 1);

    logic [DOT_W-1:0] dot_cnt;
    logic [DOT_W:0]   dot_nxt;
    logic [DOT_W-1:0] hstart;
    logic [1:0]       hrep;
    logic [1:0]       hmag;
    logic             h_done;

    // Start dot is twice the position field; count one ahead for the compare.
    always_comb begin
        hstart  = DOT_W'({hpos, 1'b0});
        dot_nxt = {1'b0, dot_cnt} + 1'b1;
        hmag    = osd_pos_pkg::size_mult(hsz);
    end

    // Restart on a line strobe; otherwise step the dot position on each enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dot_cnt <= '0;
            col     <= '0;
            gdot    <= '0;
            hrep    <= '0;
            h_on    <= 1'b0;
            h_done  <= 1'b0;
        end else if (hsync_stb) begin
            dot_cnt <= '0;
            col     <= '0;
            gdot    <= '0;
            hrep    <= '0;
            h_on    <= (hstart == '0);
            h_done  <= 1'b0;
        end else if (dot_en) begin
            if (!dot_nxt[DOT_W]) dot_cnt <= dot_nxt[DOT_W-1:0];
            if (!h_on && !h_done && dot_nxt == {1'b0, hstart}) begin
                h_on <= 1'b1;
            end else if (h_on) begin
                if (hrep + 2'd1 < hmag) begin
                    hrep <= hrep + 2'd1;
                end else begin
                    hrep <= '0;
                    if (gdot == GD_W'(GLYPH_W - 1)) begin
                        gdot <= '0;
                        if (col == COL_W'(COLS - 1)) begin
                            h_on   <= 1'b0;
                            h_done <= 1'b1;
                        end else begin
                            col <= col + 1'b1;
                        end
                    end else begin
                        gdot <= gdot + 1'b1;
                    end
                end
            end
        end
    end

    // R7: column and glyph dot stay within the grid while active
    assert_col_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        h_on |-> (col < COL_W'(COLS) && gdot < GD_W'(GLYPH_W)));

    // R8: a line strobe restarts the dot position
    assert_hsync_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hsync_stb |=> (col == '0 && gdot == '0 && dot_cnt == '0));

    // R10: without an enable or a strobe the position holds
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!dot_en && !hsync_stb) |=> ($stable(col) && $stable(gdot) && $stable(h_on)));

    // R3: the area opens exactly on the start dot
    assert_start_dot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(h_on) |-> (dot_cnt == $past(hstart)));

endmodule

// File: rtl/osd_raster_pos.sv
// Module: top of the OSD raster position generator. It ties the settings
// registers to the vertical and horizontal trackers. The horizontal size
// code is chosen by whether the current text row is the first one.
// Assumes one-cycle sync strobes in the clk domain.
module osd_raster_pos #(
    parameter int GLYPH_W  = 12,
    parameter int GLYPH_H  = 18,
    parameter int COLS     = 24,
    parameter int ROWS     = 12,
    parameter int ROWS_ALT = 10,
    parameter int POS_W    = 6,
    parameter int OFS_525  = 20,
    parameter int OFS_625  = 25,
    localparam int ROW_W   = $clog2(ROWS),
    localparam int COL_W   = $clog2(COLS),
    localparam int GL_W    = $clog2(GLYPH_H),
    localparam int GD_W    = $clog2(GLYPH_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic             cfg_line625,
    input  logic [POS_W-1:0] cfg_vpos,
    input  logic [POS_W-1:0] cfg_hpos,
    input  logic [1:0]       cfg_vsize_first,
    input  logic [1:0]       cfg_vsize_rest,
    input  logic [1:0]       cfg_hsize_first,
    input  logic [1:0]       cfg_hsize_rest,
    input  logic             cfg_rows10,
    input  logic             hsync_stb,
    input  logic             vsync_stb,
    input  logic             dot_en,
    output logic [ROW_W-1:0] txt_row,
    output logic [COL_W-1:0] txt_col,
    output logic [GL_W-1:0]  dot_row,
    output logic [GD_W-1:0]  dot_col,
    output logic             char_active
);

    logic             r_line625;
    logic [POS_W-1:0] r_vpos;
    logic [POS_W-1:0] r_hpos;
    logic [1:0]       r_vsz_first;
    logic [1:0]       r_vsz_rest;
    logic [1:0]       r_hsz_first;
    logic [1:0]       r_hsz_rest;
    logic             r_rows10;
    logic [1:0]       hsz_sel;
    logic             v_on;
    logic             h_on;

    osd_cfg_regs #(.POS_W(POS_W)) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_load     (cfg_load),
        .in_line625   (cfg_line625),
        .in_vpos      (cfg_vpos),
        .in_hpos      (cfg_hpos),
        .in_vsz_first (cfg_vsize_first),
        .in_vsz_rest  (cfg_vsize_rest),
        .in_hsz_first (cfg_hsize_first),
        .in_hsz_rest  (cfg_hsize_rest),
        .in_rows10    (cfg_rows10),
        .line625      (r_line625),
        .vpos         (r_vpos),
        .hpos         (r_hpos),
        .vsz_first    (r_vsz_first),
        .vsz_rest     (r_vsz_rest),
        .hsz_first    (r_hsz_first),
        .hsz_rest     (r_hsz_rest),
        .rows10       (r_rows10)
    );

    osd_vert_track #(
        .GLYPH_H (GLYPH_H), .ROWS (ROWS), .ROWS_ALT (ROWS_ALT), .POS_W (POS_W),
        .OFS_A (OFS_525), .OFS_B (OFS_625), .ROW_W (ROW_W), .GL_W (GL_W)
    ) u_vert (
        .clk       (clk),
        .rst_n     (rst_n),
        .hsync_stb (hsync_stb),
        .vsync_stb (vsync_stb),
        .line625   (r_line625),
        .vpos      (r_vpos),
        .vsz_first (r_vsz_first),
        .vsz_rest  (r_vsz_rest),
        .rows10    (r_rows10),
        .row       (txt_row),
        .gline     (dot_row),
        .v_on      (v_on)
    );

    // Row 0 takes the first-row horizontal size; other rows take the shared one.
    always_comb hsz_sel = (txt_row == '0) ? r_hsz_first : r_hsz_rest;

    osd_horz_track #(
        .GLYPH_W (GLYPH_W), .COLS (COLS), .POS_W (POS_W), .COL_W (COL_W), .GD_W (GD_W)
    ) u_horz (
        .clk       (clk),
        .rst_n     (rst_n),
        .hsync_stb (hsync_stb),
        .dot_en    (dot_en),
        .hpos      (r_hpos),
        .hsz       (hsz_sel),
        .col       (txt_col),
        .gdot      (dot_col),
        .h_on      (h_on)
    );

    // Character area: inside the grid in both directions at once.
    always_comb char_active = v_on && h_on;

endmodule

// File: tb/tb_osd_raster_pos.sv
`timescale 1ns/1ps
module tb_osd_raster_pos;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_load = 1'b0;
    logic       cfg_line625 = 1'b0;
    logic [5:0] cfg_vpos = '0;
    logic [5:0] cfg_hpos = '0;
    logic [1:0] cfg_vsize_first = '0;
    logic [1:0] cfg_vsize_rest = '0;
    logic [1:0] cfg_hsize_first = '0;
    logic [1:0] cfg_hsize_rest = '0;
    logic       cfg_rows10 = 1'b0;
    logic       hsync_stb = 1'b0;
    logic       vsync_stb = 1'b0;
    logic       dot_en = 1'b0;
    logic [3:0] txt_row;
    logic [4:0] txt_col;
    logic [4:0] dot_row;
    logic [3:0] dot_col;
    logic       char_active;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    // model copy of the loaded settings
    bit m_l625;
    int m_vp, m_hp, m_vsf, m_vsr, m_hsf, m_hsr;
    bit m_r10;

    osd_raster_pos dut (.*);

    always #2.5 clk = ~clk;

    // vector: {line625, vp, hp, vsize_first, vsize_rest, hsize_first, hsize_rest, rows10, dot gaps}
    localparam logic [22:0] VEC [5] = '{
        {1'b0, 6'd0,  6'd0,  2'b00, 2'b00, 2'b00, 2'b00, 1'b0, 1'b0},
        {1'b1, 6'd3,  6'd5,  2'b01, 2'b00, 2'b01, 2'b10, 1'b0, 1'b0},
        {1'b0, 6'd7,  6'd2,  2'b10, 2'b01, 2'b11, 2'b01, 1'b1, 1'b0},
        {1'b1, 6'd1,  6'd9,  2'b11, 2'b10, 2'b00, 2'b11, 1'b1, 1'b1},
        {1'b0, 6'd63, 6'd63, 2'b00, 2'b00, 2'b10, 2'b00, 1'b0, 1'b0}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic int mult(input int code);
        return (code == 1) ? 2 : (code == 2) ? 3 : 1;
    endfunction

    function automatic int vstart_m();
        return (m_l625 ? 25 : 20) + 2 * m_vp;
    endfunction

    function automatic int vend_m();
        return vstart_m() + 18 * mult(m_vsf) + 18 * mult(m_vsr) * ((m_r10 ? 10 : 12) - 1);
    endfunction

    // expected outputs at line L, dot P, from the requirements
    function automatic void expect_at(input int L, input int P, output bit a,
                                      output int r, output int c, output int gl, output int gd);
        int vs, d, d2, m0, m1, hm, hs, e, nr;
        a = 0; r = 0; c = 0; gl = 0; gd = 0;
        vs = vstart_m();
        nr = m_r10 ? 10 : 12;
        m0 = mult(m_vsf);
        m1 = mult(m_vsr);
        if (L < vs) return;
        d = L - vs;
        if (d < 18 * m0) begin
            r = 0; gl = d / m0;
        end else begin
            d2 = d - 18 * m0;
            r = 1 + d2 / (18 * m1);
            if (r >= nr) return;
            gl = (d2 % (18 * m1)) / m1;
        end
        hm = (r == 0) ? mult(m_hsf) : mult(m_hsr);
        hs = 2 * m_hp;
        if (P < hs) return;
        e = P - hs;
        c = e / (12 * hm);
        if (c >= 24) return;
        gd = (e % (12 * hm)) / hm;
        a = 1;
    endfunction

    task automatic check_at(input int L, input int P, input string tag);
        bit a;
        int r, c, gl, gd;
        expect_at(L, P, a, r, c, gl, gd);
        n_checks++;
        if (char_active !== a ||
            (a && (txt_row !== 4'(r) || txt_col !== 5'(c) || dot_row !== 5'(gl) || dot_col !== 4'(gd)))) begin
            n_errors++;
            $display("FAIL %s L=%0d P=%0d actual act=%0b row=%0d col=%0d gl=%0d gd=%0d expected act=%0b row=%0d col=%0d gl=%0d gd=%0d",
                     tag, L, P, char_active, txt_row, txt_col, dot_row, dot_col, a, r, c, gl, gd);
        end
    endtask

    task automatic load_cfg(input logic [22:0] v);
        {cfg_line625, cfg_vpos, cfg_hpos, cfg_vsize_first, cfg_vsize_rest,
         cfg_hsize_first, cfg_hsize_rest, cfg_rows10} = v[22:1];
        m_l625 = v[22]; m_vp = int'(v[21:16]); m_hp = int'(v[15:10]);
        m_vsf = int'(v[9:8]); m_vsr = int'(v[7:6]); m_hsf = int'(v[5:4]);
        m_hsr = int'(v[3:2]); m_r10 = v[1];
        cfg_load = 1'b1;
        tick();
        cfg_load = 1'b0;
    endtask

    task automatic pulse_vsync();
        vsync_stb = 1'b1;
        tick();
        vsync_stb = 1'b0;
    endtask

    task automatic pulse_hsync();
        hsync_stb = 1'b1;
        tick();
        hsync_stb = 1'b0;
    endtask

    // one full frame: every line checked at dot 0, probe lines swept fully
    task automatic run_frame(input bit gap);
        int vs, vsb, ve, len, hmx;
        vs  = vstart_m();
        vsb = vs + 18 * mult(m_vsf);
        ve  = vend_m();
        hmx = (mult(m_hsf) > mult(m_hsr)) ? mult(m_hsf) : mult(m_hsr);
        len = 2 * m_hp + 288 * hmx + 3;
        pulse_vsync();
        check_at(0, 0, "R8");
        for (int L = 1; L <= ve + 2; L++) begin
            pulse_hsync();
            check_at(L, 0, "R2 R6");
            if (L % 37 == 0 || L == vs - 1 || L == vs || L == vsb - 1 || L == vsb ||
                L == ve - 1 || L == ve) begin
                for (int p = 1; p <= len; p++) begin
                    if (gap) begin
                        tick();
                        check_at(L, p - 1, "R10");
                    end
                    dot_en = 1'b1;
                    tick();
                    dot_en = 1'b0;
                    check_at(L, p, "R1 R3 R4 R5 R7");
                end
            end
        end
    endtask

    // watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        // R9: reset clears outputs
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        n_checks++;
        if (char_active !== 1'b0 || txt_row !== '0 || txt_col !== '0 || dot_row !== '0 || dot_col !== '0) begin
            n_errors++;
            $display("FAIL R9 reset outputs actual act=%0b row=%0d col=%0d gl=%0d gd=%0d expected all 0",
                     char_active, txt_row, txt_col, dot_row, dot_col);
        end

        // R9: settings ignored without cfg_load; cleared values give start line 20, dot 0
        m_l625 = 0; m_vp = 0; m_hp = 0; m_vsf = 0; m_vsr = 0; m_hsf = 0; m_hsr = 0; m_r10 = 0;
        cfg_line625 = 1'b1; cfg_vpos = 6'd10; cfg_hpos = 6'd4; cfg_vsize_first = 2'b10;
        pulse_vsync();
        for (int L = 1; L <= 21; L++) begin
            pulse_hsync();
            if (L >= 19) check_at(L, 0, "R9");
        end

        // main vector table
        for (int i = 0; i < 5; i++) begin
            load_cfg(VEC[i]);
            run_frame(VEC[i][0]);
        end

        // R8: mid-line hsync together with dot_en restarts the dots
        load_cfg(VEC[0]);
        pulse_vsync();
        for (int L = 1; L <= 21; L++) pulse_hsync();
        for (int p = 1; p <= 50; p++) begin
            dot_en = 1'b1;
            tick();
        end
        check_at(21, 50, "R3");
        hsync_stb = 1'b1;
        tick();
        hsync_stb = 1'b0;
        dot_en = 1'b0;
        check_at(22, 0, "R8");

        // R7: dots past column 23 stay off, no wrap
        for (int p = 1; p <= 300; p++) begin
            dot_en = 1'b1;
            tick();
        end
        dot_en = 1'b0;
        check_at(22, 300, "R7");

        // R8: vsync mid-frame clears the area and restarts the line count
        pulse_hsync();
        check_at(23, 0, "R8");
        pulse_vsync();
        check_at(0, 0, "R8");
        pulse_hsync();
        check_at(1, 0, "R8");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule